// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a single-port synchronous burst SRAM with a small internal array. It takes one command per clock, either a read, a write or a deselect. Reads and writes can follow each other in any order with no idle cycle between them. A command is registered on a rising edge. For a read, the data appears combinationally during the cycle that follows that edge, which is the flow-through timing. For a write, the data is sampled one enabled edge after the address. The captured write is held in a pending register until the next enabled edge, when it is committed to the array. Reads that hit the pending entry take its enabled bytes through a bypass, so a read right after a write always returns the new data.

A load cycle brings in a fresh address. A continue cycle steps a two-bit burst counter and keeps the operation of the current burst. The order of the steps within a group of four words is linear or interleaved. An active-low clock enable stalls the whole pipeline. Three chip enables select the device. An asynchronous output enable and a sleep input both force the data lanes off.

The pad ring builds the bidirectional data bus from three signals. `d_in` carries the incoming data, `q_out` carries the outgoing data, and `q_drive` turns the tri-state driver on. When `q_drive` is low the bus is in high impedance. Each byte lane is nine bits wide, eight data bits and one parity bit.

Top module: `zt_sram`

## Requirements
- R1: On each edge with `clk_en_n` low, a new command is registered, and reads and writes follow each other with no idle cycle. A read loaded on edge k presents the word on `q_out`, with `q_drive` high, from just after edge k until the next enabled edge.
- R2: Write data is sampled on `d_in` at the first enabled edge after the edge that registered the write command. Byte lane b of a word is bits [9b+8:9b], and bit 9b+8 is the parity bit of that lane.
- R3: The byte strobes `bw_n` are active low, and bit b controls lane b. A write with every strobe high leaves the word unchanged.
- R4: A read of an address whose write data was captured on the same edge, or on any earlier edge, returns the new bytes merged with the old ones.
- R5: An edge with `clk_en_n` high is ignored. The command, the burst position and any write still waiting for its data all hold, no data is captured, nothing is written, and a read being shown stays on `q_out`.
- R6: `q_drive` is low throughout the data phase of a write (the cycle after a write command edge), whatever the level of `oe_n`.
- R7: `q_drive` follows `oe_n` combinationally. While `oe_n` is high, `q_drive` is low.
- R8: On a load cycle (`adv_ld` low), the device is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. Otherwise the cycle is a deselect and `q_drive` stays low.
- R9: A cycle with `adv_ld` high continues the current operation (read, write or deselect) at the next burst address. The chip enables and `wr_n` are ignored on such a cycle, and `bw_n` is sampled afresh for each written word.
- R10: The word offset within the group of four is (start + n) mod 4 when `order` is 0, and start XOR n when `order` is 1. The upper address bits do not change, the burst wraps after four words, and `order` is latched on the load cycle.
- R11: An edge with `sleep` high makes the command idle. While `sleep` is high, `q_drive` is low, and it stays low after `sleep` falls until a new read is loaded.
- R12: Reset is synchronous and active high. It makes the command idle and drops a write whose data phase falls on the reset edge. Data captured on an earlier edge is still committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the edge |
| addr | input | ADDR_W | Word address for load cycles |
| adv_ld | input | 1 | 1 continues the burst, 0 loads a new address |
| wr_n | input | 1 | 0 selects a write, 1 selects a read on a load cycle |
| bw_n | input | NBYTES | Byte write strobes, active low, one per lane |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request, active high |
| d_in | input | NBYTES*LANE_W | Write data from the pad ring |
| q_out | output | NBYTES*LANE_W | Read data toward the pad ring |
| q_drive | output | 1 | Pad driver enable; low means high impedance |

## Verification
The bench builds the block with ADDR_W=5, NBYTES=4 and LANE_W=9. With 32 words, it can fill the whole array back to back and read it back within a short run. Bursts can start at the top group of four (address 31), so the wrap of the offset is tested while the upper address bits stay fixed. Four lanes give enough strobe patterns to test partial merges through the pending-write bypass. They also allow the all-strobes-off case.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Offset of step n inside a four-word group.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv,
  input  logic              sel,
  input  logic              wr_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic              order,
  output op_e               op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [NBYTES-1:0] mask
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic              ilv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op     <= OP_IDLE;
      step_q <= '0;
      base_q <= '0;
      ilv_q  <= 1'b0;
      mask   <= '0;
    end else if (sleep) begin
      op <= OP_IDLE;
    end else if (!stall) begin
      if (!adv) begin
        op     <= !sel ? OP_IDLE : (wr_n ? OP_RD : OP_WR);
        base_q <= addr;
        step_q <= '0;
        ilv_q  <= order;
      end else begin
        step_q <= step_q + 2'd1;
      end
      mask <= ~bw_n;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_q, ilv_q)};

endmodule

// File: rtl/zt_write_hold.sv
module zt_write_hold #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int LANE_W = 9,
  localparam int DW    = NBYTES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              cap,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [NBYTES-1:0] cap_mask,
  input  logic [DW-1:0]     din,
  output logic              hvld,
  output logic [ADDR_W-1:0] haddr,
  output logic [NBYTES-1:0] hmask,
  output logic [DW-1:0]     hdata,
  output logic              mem_we
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hvld <= 1'b0;
    end else if (!stall) begin
      hvld  <= cap;
      haddr <= cap_addr;
      hmask <= cap_mask;
      hdata <= din;
    end
  end

  // The held entry retires on any enabled edge, and on a reset edge.
  assign mem_we = hvld && (!stall || rst);

endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int LANE_W = 9,
  localparam int DW    = NBYTES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NBYTES-1:0] wbe,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[b]) lane_mem[waddr] <= wdata[b*LANE_W +: LANE_W];
    end

    assign rdata[b*LANE_W +: LANE_W] = lane_mem[raddr];
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int LANE_W = 9,
  localparam int DW    = NBYTES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic              oe_n,
  input  logic              order,
  input  logic              sleep,
  input  logic [DW-1:0]     d_in,
  output logic [DW-1:0]     q_out,
  output logic              q_drive
);

  op_e               op_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [NBYTES-1:0] cmd_mask;
  logic              hvld;
  logic [ADDR_W-1:0] haddr;
  logic [NBYTES-1:0] hmask;
  logic [DW-1:0]     hdata;
  logic              mem_we;
  logic [DW-1:0]     st_rd;
  logic [DW-1:0]     merged;
  logic              sel;
  logic              hit;

  assign sel = !en_a_n && en_b && !en_c_n;

  zt_burst_ctl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .stall    (clk_en_n),
    .sleep    (sleep),
    .addr     (addr),
    .adv      (adv_ld),
    .sel      (sel),
    .wr_n     (wr_n),
    .bw_n     (bw_n),
    .order    (order),
    .op       (op_q),
    .cur_addr (cur_addr),
    .mask     (cmd_mask)
  );

  zt_write_hold #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .LANE_W(LANE_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .stall    (clk_en_n),
    .cap      (op_q == OP_WR),
    .cap_addr (cur_addr),
    .cap_mask (cmd_mask),
    .din      (d_in),
    .hvld     (hvld),
    .haddr    (haddr),
    .hmask    (hmask),
    .hdata    (hdata),
    .mem_we   (mem_we)
  );

  zt_store #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .LANE_W(LANE_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (haddr),
    .wbe   (hmask),
    .wdata (hdata),
    .raddr (cur_addr),
    .rdata (st_rd)
  );

  assign hit = hvld && (haddr == cur_addr);

  always_comb begin
    for (int b = 0; b < NBYTES; b++) begin
      merged[b*LANE_W +: LANE_W] = (hit && hmask[b]) ? hdata[b*LANE_W +: LANE_W]
                                                     : st_rd[b*LANE_W +: LANE_W];
    end
  end

  assign q_drive = (op_q == OP_RD) && !oe_n && !sleep;
  assign q_out   = q_drive ? merged : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              sleep,
  input logic              oe_n,
  input logic              adv_ld,
  input logic              en_a_n,
  input logic              en_b,
  input logic              en_c_n,
  input logic              q_drive,
  input op_e               op,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              mem_we
);

  // R5
  stall_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |-> !mem_we);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en_n && !sleep) |=> (op == $past(op)) && (cur_addr == $past(cur_addr)));

  // R6
  wr_phase_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR) |-> !q_drive);

  // R7
  oe_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !q_drive);

  // R8
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !sleep && !adv_ld && !(!en_a_n && en_b && !en_c_n)) |=> !q_drive);

  // R9
  burst_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !sleep && adv_ld) |=>
      (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])) && (op == $past(op)));

  // R11
  sleep_idle_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (op == OP_IDLE) && !q_drive);

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_en_n (clk_en_n),
  .sleep    (sleep),
  .oe_n     (oe_n),
  .adv_ld   (adv_ld),
  .en_a_n   (en_a_n),
  .en_b     (en_b),
  .en_c_n   (en_c_n),
  .q_drive  (q_drive),
  .op       (op_q),
  .cur_addr (cur_addr),
  .mem_we   (mem_we)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int AW    = 5;
  localparam int NB    = 4;
  localparam int LW    = 9;
  localparam int DW    = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          adv_ld = 1'b0;
  logic          wr_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic          en_a_n = 1'b1;
  logic          en_b = 1'b0;
  logic          en_c_n = 1'b1;
  logic          oe_n = 1'b0;
  logic          order = 1'b0;
  logic          sleep = 1'b0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic          q_drive;

  int checks = 0;
  int errors = 0;
  string tag = "R12";

  // Reference state: the memory as seen after every captured write.
  logic [DW-1:0] mem_m [DEPTH];
  int            m_op = 0;   // 0 idle, 1 read, 2 write
  int            m_base = 0;
  int            m_step = 0;
  logic          m_ilv = 1'b0;
  logic [NB-1:0] m_mask = '0;

  always #2 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .NBYTES(NB), .LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .addr(addr), .adv_ld(adv_ld),
    .wr_n(wr_n), .bw_n(bw_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .oe_n(oe_n), .order(order), .sleep(sleep), .d_in(d_in),
    .q_out(q_out), .q_drive(q_drive)
  );

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'(a * 1103 + s * 7919 + 32'h5a5a_3c3c) ^ (DW'(s) << 20);
  endfunction

  function automatic int m_cur();
    int off;
    off = m_ilv ? ((m_base & 3) ^ m_step) : (((m_base & 3) + m_step) & 3);
    return (m_base & ~3) | off;
  endfunction

  task automatic model_edge();
    int a;
    if (rst) begin
      m_op = 0;
      m_step = 0;
    end else begin
      if (!clk_en_n && m_op == 2) begin
        a = m_cur();
        for (int b = 0; b < NB; b++)
          if (m_mask[b]) mem_m[a][b*LW +: LW] = d_in[b*LW +: LW];
      end
      if (sleep) m_op = 0;
      else if (!clk_en_n) begin
        if (!adv_ld) begin
          m_op   = (!en_a_n && en_b && !en_c_n) ? (wr_n ? 1 : 2) : 0;
          m_base = int'(addr);
          m_step = 0;
          m_ilv  = order;
        end else begin
          m_step = (m_step + 1) & 3;
        end
        m_mask = ~bw_n;
      end
    end
  endtask

  task automatic compare();
    logic          exp_drv;
    logic [DW-1:0] exp_q;
    exp_drv = (m_op == 1) && !oe_n && !sleep;
    checks++;
    if (q_drive !== exp_drv) begin
      errors++;
      $display("FAIL %s q_drive actual %0b expected %0b at %0t", tag, q_drive, exp_drv, $time);
    end
    if (exp_drv) begin
      exp_q = mem_m[m_cur()];
      checks++;
      if (q_out !== exp_q) begin
        errors++;
        $display("FAIL %s q_out actual %h expected %h at %0t", tag, q_out, exp_q, $time);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic go(input logic a_adv, input logic a_wr_n, input int a_addr,
                    input logic [NB-1:0] a_bw_n, input logic [DW-1:0] a_din);
    adv_ld = a_adv;
    wr_n   = a_wr_n;
    addr   = AW'(a_addr);
    bw_n   = a_bw_n;
    d_in   = a_din;
    tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    // R12 reset state
    tag = "R12";
    tick();
    tick();
    rst = 1'b0;
    en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;

    // R1 R2 fill back to back, data one cycle behind its address
    tag = "R2";
    go(0, 0, 0, '0, '0);
    for (int a = 1; a < DEPTH; a++) go(0, 0, a, '0, pat(a - 1, 0));
    tag = "R1";
    go(0, 1, 0, '0, pat(DEPTH - 1, 0));
    for (int a = 1; a < DEPTH; a++) go(0, 1, a, '0, '0);

    // R4 read right after write, same address, full then partial
    tag = "R4";
    go(0, 0, 7, '0, '0);
    go(0, 1, 7, '0, pat(7, 1));
    go(0, 0, 8, 4'b1010, '0);
    go(0, 1, 8, '0, pat(8, 2));
    go(0, 0, 9, 4'b0110, '0);
    go(0, 0, 9, 4'b1001, pat(9, 3));
    go(0, 1, 9, '0, pat(9, 4));
    go(0, 1, 10, '0, '0);
    go(0, 0, 10, '0, '0);
    go(0, 1, 9, '0, pat(10, 5));
    go(0, 1, 10, '0, '0);

    // R3 write with every strobe off changes nothing
    tag = "R3";
    go(0, 0, 11, 4'b1111, '0);
    go(0, 1, 11, '0, pat(11, 6));
    go(0, 0, 12, 4'b1110, '0);
    go(0, 1, 12, '0, pat(12, 7));

    // R5 stall with a write waiting for data, then with a read on show
    tag = "R5";
    go(0, 0, 13, '0, '0);
    clk_en_n = 1'b1;
    go(0, 1, 3, '0, pat(99, 9));
    go(0, 0, 4, 4'b0000, pat(98, 9));
    clk_en_n = 1'b0;
    go(0, 1, 13, '0, pat(13, 8));
    clk_en_n = 1'b1;
    go(0, 0, 14, '0, pat(97, 9));
    go(0, 1, 15, '0, pat(96, 9));
    clk_en_n = 1'b0;
    go(0, 1, 14, '0, '0);

    // R6 write data phases with the output enable asserted
    tag = "R6";
    go(0, 0, 16, '0, '0);
    go(0, 0, 17, '0, pat(16, 1));
    go(0, 1, 16, '0, pat(17, 1));
    go(0, 1, 17, '0, '0);

    // R7 asynchronous output enable
    tag = "R7";
    go(0, 1, 18, '0, '0);
    oe_n = 1'b1;
    #1;
    checks++;
    if (q_drive !== 1'b0) begin
      errors++;
      $display("FAIL R7 q_drive actual %0b expected 0", q_drive);
    end
    go(0, 1, 19, '0, '0);
    oe_n = 1'b0;
    #1;
    checks++;
    if (q_drive !== 1'b1 || q_out !== mem_m[19]) begin
      errors++;
      $display("FAIL R7 q_out actual %h expected %h", q_out, mem_m[19]);
    end
    @(negedge clk);

    // R8 each chip enable inactive on its own
    tag = "R8";
    en_a_n = 1'b1; go(0, 1, 5, '0, '0); en_a_n = 1'b0;
    go(0, 1, 6, '0, '0);
    en_b = 1'b0;   go(0, 1, 5, '0, '0); en_b = 1'b1;
    en_c_n = 1'b1; go(0, 0, 5, '0, '0); en_c_n = 1'b0;
    tag = "R9";
    go(1, 1, 0, '0, pat(95, 9));
    go(0, 1, 5, '0, '0);

    // R9 R10 linear read burst wrapping at the top group, enables ignored
    tag = "R10";
    order = 1'b0;
    go(0, 1, 31, '0, '0);
    en_b = 1'b0;
    go(1, 0, 0, '0, '0);
    go(1, 0, 0, '0, '0);
    go(1, 1, 0, '0, '0);
    go(1, 1, 0, '0, '0);
    en_b = 1'b1;

    // interleaved read burst, order changed mid burst
    order = 1'b1;
    go(0, 1, 22, '0, '0);
    order = 1'b0;
    go(1, 1, 0, '0, '0);
    go(1, 1, 0, '0, '0);
    go(1, 1, 0, '0, '0);

    // R9 interleaved write burst with fresh strobes, read back linear
    tag = "R9";
    order = 1'b1;
    go(0, 0, 25, 4'b0000, '0);
    go(1, 1, 0, 4'b0101, pat(25, 2));
    go(1, 1, 0, 4'b1100, pat(24, 2));
    go(1, 0, 0, 4'b0011, pat(27, 2));
    order = 1'b0;
    go(0, 1, 24, '0, pat(26, 2));
    go(1, 1, 0, '0, '0);
    go(1, 1, 0, '0, '0);
    go(1, 1, 0, '0, '0);

    // R11 sleep
    tag = "R11";
    go(0, 1, 20, '0, '0);
    sleep = 1'b1;
    go(0, 1, 21, '0, '0);
    go(0, 1, 21, '0, '0);
    sleep = 1'b0;
    go(1, 1, 0, '0, '0);
    go(0, 1, 21, '0, '0);

    // R12 reset drops the write whose data phase meets it
    tag = "R12";
    go(0, 0, 26, '0, '0);
    go(0, 0, 27, '0, pat(26, 5));
    rst = 1'b1;
    go(0, 1, 0, '0, pat(27, 5));
    rst = 1'b0;
    go(0, 1, 26, '0, '0);
    go(0, 1, 27, '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule